// File: doc/BRIEF.md
# Palette and Pixel Format Expander

This block sits between the frame-buffer fetch path and the display output of a graphics pipeline. It takes a valid-qualified stream of pixel words, interprets each word according to a format selection that travels with it, and emits a registered 24-bit RGB stream. The blank flag travels alongside each pixel.

The block holds a 256-entry colour lookup table. Software loads it in two steps. It first writes an entry number to an index register. It then writes colour values to a data register, and the index steps forward after each of those writes.

Three formats are handled:
- **8-bit indexed:** the low byte of the pixel selects a table entry.
- **16-bit direct:** the pixel is either 5-6-5 or 5-5-5 RGB, and each component is widened to 8 bits.
- **24-bit:** each byte of the pixel either passes straight through, or is used as an index into the table for its own channel. A bypass flag chooses between the two.

Every format reaches the output after the same two clock cycles.

Top module: `clut_pixel_expander`

## Requirements
- R1: After reset, out_valid, out_blank and out_rgb are 0, the table index register is 0 and every table entry reads as 24'h000000.
- R2: out_valid and out_blank equal in_valid and in_blank from exactly two clock edges earlier, in every format.
- R3: With in_fmt = 2'd0 (indexed), out_rgb equals the table entry selected by in_pix[7:0]; entries store red in bits 23:16, green in 15:8 and blue in 7:0.
- R4: With in_fmt = 2'd1 and in_sub565 = 1, in_pix[15:11], [10:5] and [4:0] are red, green and blue; each component is widened by appending its own top bits (5-bit v gives {v, v[4:2]}, 6-bit v gives {v, v[5:4]}). in_pix[23:16] is ignored.
- R5: With in_fmt = 2'd1 and in_sub565 = 0, in_pix[14:10], [9:5] and [4:0] are red, green and blue, each widened as {v, v[4:2]}. in_pix[15] and in_pix[23:16] are ignored.
- R6: With in_fmt = 2'd2 and in_bypass = 1, out_rgb equals in_pix[23:0] unchanged.
- R7: With in_fmt = 2'd2 and in_bypass = 0, out_rgb is {entry[in_pix[23:16]][23:16], entry[in_pix[15:8]][15:8], entry[in_pix[7:0]][7:0]}.
- R8: out_rgb is 24'h000000 whenever out_valid is 0 or out_blank is 1.
- R9: A register write with reg_sel = 0 loads reg_wdata[7:0] into the index register. A write with reg_sel = 1 stores reg_wdata[23:0] into the entry at the index and then increments the index, wrapping from 255 to 0. Without a write, the index holds its value.
- R10: A lookup that reaches the table on the same clock edge as a data write to the same entry returns the entry's previous contents.
- R11: in_fmt = 2'd3 is reserved and produces out_rgb = 24'h000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the index register, 1 selects the colour data register |
| reg_wdata | input | 24 | Write data (index in bits 7:0, or colour value) |
| in_valid | input | 1 | Pixel qualifier |
| in_blank | input | 1 | Blanking flag carried with the pixel |
| in_fmt | input | 2 | 0 indexed, 1 16-bit direct, 2 24-bit, 3 reserved |
| in_sub565 | input | 1 | 16-bit layout: 1 for 5-6-5, 0 for 5-5-5 |
| in_bypass | input | 1 | 24-bit format: 1 passes pixels straight through |
| in_pix | input | 24 | Pixel word |
| out_valid | output | 1 | Output qualifier |
| out_blank | output | 1 | Delayed blanking flag |
| out_rgb | output | 24 | Output colour, red in bits 23:16 |

## Verification
The assertions assume that reg_we, reg_sel and the pixel inputs are known and change only away from the rising edge. They also assume that the format controls are sampled together with the pixel they describe, rather than being held steady as a mode setting.

The latency property assumes that in_valid is driven from the first edge after reset. The bench clears every input during reset for this reason.

The bench drives all inputs on the falling edge. It issues index and data writes as single-cycle strobes, except in the collision case, where a data write and a lookup of the same entry are placed on purpose on the same edge.

// File: rtl/clut_pkg.sv
`timescale 1ns/1ps
package clut_pkg;

    localparam int CH_W  = 8;
    localparam int RGB_W = 3 * CH_W;

    typedef enum logic [1:0] {
        FMT_IDX8  = 2'd0,
        FMT_RGB16 = 2'd1,
        FMT_RGB24 = 2'd2,
        FMT_RSVD  = 2'd3
    } pix_fmt_e;

    function automatic logic [CH_W-1:0] widen5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [CH_W-1:0] widen6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction

endpackage

// File: rtl/clut_table.sv
`timescale 1ns/1ps
module clut_table #(
    parameter int AW    = 8,
    parameter int DW    = 24,
    parameter int NREAD = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [DW-1:0]        wr_data,
    input  logic [NREAD*AW-1:0]  rd_addr,
    output logic [NREAD*DW-1:0]  rd_data
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] idx;
    } tbl_state_t;

    tbl_state_t    st_d, st_q;
    logic          mem_we;
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        st_d   = st_q;
        mem_we = wr_en && wr_sel;
        if (wr_en && !wr_sel) begin
            st_d.idx = wr_data[AW-1:0];
        end else if (mem_we) begin
            st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            st_q <= st_d;
            if (mem_we) begin
                mem_q[st_q.idx] <= wr_data;
            end
        end
    end

    for (genvar g = 0; g < NREAD; g++) begin : g_rd
        assign rd_data[g*DW +: DW] = mem_q[rd_addr[g*AW +: AW]];
    end

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (st_q.idx == AW'($past(st_q.idx) + 1'b1))); // R9
    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (st_q.idx == $past(wr_data[AW-1:0]))); // R9
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.idx)); // R9

endmodule

// File: rtl/rgb16_unpack.sv
`timescale 1ns/1ps
module rgb16_unpack
    import clut_pkg::*;
(
    input  logic [15:0]      word16,
    input  logic             use565,
    output logic [RGB_W-1:0] rgb
);
    logic [CH_W-1:0] red, grn, blu;

    always_comb begin
        blu = widen5(word16[4:0]);
        if (use565) begin
            red = widen5(word16[15:11]);
            grn = widen6(word16[10:5]);
        end else begin
            red = widen5(word16[14:10]);
            grn = widen5(word16[9:5]);
        end
        rgb = {red, grn, blu};
    end

endmodule

// File: rtl/clut_pixel_expander.sv
`timescale 1ns/1ps
module clut_pixel_expander
    import clut_pkg::*;
#(
    parameter int LUT_AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [23:0]      reg_wdata,
    input  logic             in_valid,
    input  logic             in_blank,
    input  logic [1:0]       in_fmt,
    input  logic             in_sub565,
    input  logic             in_bypass,
    input  logic [23:0]      in_pix,
    output logic             out_valid,
    output logic             out_blank,
    output logic [23:0]      out_rgb
);
    localparam int NRD = 3;

    typedef struct packed {
        logic             valid;
        logic             blank;
        pix_fmt_e         fmt;
        logic             bypass;
        logic [RGB_W-1:0] direct;
        logic [RGB_W-1:0] lut_full;
        logic [RGB_W-1:0] lut_chan;
    } stage1_t;

    typedef struct packed {
        logic             valid;
        logic             blank;
        logic [RGB_W-1:0] rgb;
    } stage2_t;

    stage1_t s1_d, s1_q;
    stage2_t s2_d, s2_q;
    logic [1:0] warm_q;

    logic [NRD*LUT_AW-1:0] rd_addr;
    logic [NRD*RGB_W-1:0]  rd_data;
    logic [RGB_W-1:0]      rgb16;

    // Read ports: 0 = red byte, 1 = green byte, 2 = blue byte / index
    assign rd_addr = {in_pix[LUT_AW-1:0], in_pix[8 +: LUT_AW], in_pix[16 +: LUT_AW]};

    clut_table #(
        .AW    (LUT_AW),
        .DW    (RGB_W),
        .NREAD (NRD)
    ) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_sel  (reg_sel),
        .wr_data (reg_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    rgb16_unpack unpack_i (
        .word16 (in_pix[15:0]),
        .use565 (in_sub565),
        .rgb    (rgb16)
    );

    always_comb begin
        s1_d.valid    = in_valid;
        s1_d.blank    = in_blank;
        s1_d.fmt      = pix_fmt_e'(in_fmt);
        s1_d.bypass   = in_bypass;
        s1_d.direct   = (pix_fmt_e'(in_fmt) == FMT_RGB24) ? in_pix : rgb16;
        s1_d.lut_full = rd_data[2*RGB_W +: RGB_W];
        s1_d.lut_chan = {rd_data[0*RGB_W + 16 +: CH_W],
                         rd_data[1*RGB_W + 8  +: CH_W],
                         rd_data[2*RGB_W + 0  +: CH_W]};
    end

    always_comb begin
        s2_d.valid = s1_q.valid;
        s2_d.blank = s1_q.blank;
        unique case (s1_q.fmt)
            FMT_IDX8:  s2_d.rgb = s1_q.lut_full;
            FMT_RGB16: s2_d.rgb = s1_q.direct;
            FMT_RGB24: s2_d.rgb = s1_q.bypass ? s1_q.direct : s1_q.lut_chan;
            default:   s2_d.rgb = '0;
        endcase
        if (!s1_q.valid || s1_q.blank) begin
            s2_d.rgb = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= '0;
            s2_q   <= '0;
            warm_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
            if (warm_q != 2'd2) begin
                warm_q <= warm_q + 2'd1;
            end
        end
    end

    assign out_valid = s2_q.valid;
    assign out_blank = s2_q.blank;
    assign out_rgb   = s2_q.rgb;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R2
    AST_BLANK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (out_blank == $past(in_blank, 2))); // R2
    AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid || out_blank) |-> (out_rgb == '0)); // R8
    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && !s1_q.blank && s1_q.fmt == FMT_RGB24 && s1_q.bypass)
        |=> (out_rgb == $past(s1_q.direct))); // R6
    AST_RSVD_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.fmt == FMT_RSVD) |=> (out_rgb == '0)); // R11

endmodule

// File: tb/clut_pixel_expander_tb.sv
`timescale 1ns/1ps
module clut_pixel_expander_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_sel = 1'b0;
    logic [23:0] reg_wdata = '0;
    logic        in_valid = 1'b0, in_blank = 1'b0, in_sub565 = 1'b0, in_bypass = 1'b0;
    logic [1:0]  in_fmt = 2'd0;
    logic [23:0] in_pix = '0;
    logic        out_valid, out_blank;
    logic [23:0] out_rgb;

    int n_run  = 0;
    int n_fail = 0;
    logic [23:0] model [256];

    always #2 clk = ~clk;

    clut_pixel_expander dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .in_valid(in_valid), .in_blank(in_blank), .in_fmt(in_fmt),
        .in_sub565(in_sub565), .in_bypass(in_bypass), .in_pix(in_pix),
        .out_valid(out_valid), .out_blank(out_blank), .out_rgb(out_rgb)
    );

    typedef struct packed {
        logic [1:0]  fmt;
        logic        sub;
        logic        byp;
        logic        blank;
        logic [23:0] pix;
        logic [23:0] exp;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{2'd1, 1'b1, 1'b0, 1'b0, 24'h00F800, 24'hFF0000},  // R4
        '{2'd1, 1'b1, 1'b0, 1'b0, 24'h0007E0, 24'h00FF00},  // R4
        '{2'd1, 1'b1, 1'b0, 1'b0, 24'h00001F, 24'h0000FF},  // R4
        '{2'd1, 1'b1, 1'b0, 1'b0, 24'h008410, 24'h848284},  // R4
        '{2'd1, 1'b1, 1'b0, 1'b0, 24'h005555, 24'h52AAAD},  // R4
        '{2'd1, 1'b1, 1'b0, 1'b0, 24'hFF0000, 24'h000000},  // R4 upper ignored
        '{2'd1, 1'b0, 1'b0, 1'b0, 24'h00FC00, 24'hFF0000},  // R5 bit15 ignored
        '{2'd1, 1'b0, 1'b0, 1'b0, 24'h0003E0, 24'h00FF00},  // R5
        '{2'd2, 1'b0, 1'b1, 1'b0, 24'h123456, 24'h123456},  // R6
        '{2'd3, 1'b0, 1'b1, 1'b0, 24'hABCDEF, 24'h000000},  // R11
        '{2'd2, 1'b0, 1'b1, 1'b1, 24'hFFFFFF, 24'h000000}   // R8
    };

    function automatic logic [23:0] pal_val(input int i);
        logic [7:0] b;
        b = 8'(i);
        return {b ^ 8'h5A, ~b, b + 8'd3};
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns output two edges later
    task automatic pixel(input logic [1:0] fmt, input logic sub, input logic byp,
                         input logic blank, input logic [23:0] pix, output logic [23:0] rgb);
        in_valid = 1'b1; in_fmt = fmt; in_sub565 = sub; in_bypass = byp;
        in_blank = blank; in_pix = pix;
        @(negedge clk);
        in_valid = 1'b0; in_blank = 1'b0;
        @(negedge clk);
        rgb = out_rgb;
    endtask

    task automatic reg_write(input logic sel, input logic [23:0] data);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [23:0] got;
        logic        hv [64];
        logic        hb [64];
        for (int i = 0; i < 256; i++) model[i] = 24'h0;

        repeat (3) @(negedge clk);
        check("R1 out_rgb", out_rgb, 24'h0);
        check("R1 out_valid/out_blank", {23'h0, out_valid | out_blank}, 24'h0);
        rst_n = 1'b1;
        @(negedge clk);

        pixel(2'd0, 1'b0, 1'b0, 1'b0, 24'h000077, got);
        check("R1 table cleared", got, 24'h0);

        for (int v = 0; v < NVEC; v++) begin
            pixel(VEC[v].fmt, VEC[v].sub, VEC[v].byp, VEC[v].blank, VEC[v].pix, got);
            check($sformatf("R4/R5/R6/R8/R11 vector %0d", v), got, VEC[v].exp);
        end

        // Fill table from reset index 0 with auto-increment (R9, R1)
        for (int i = 0; i < 256; i++) begin
            reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = pal_val(i);
            model[i] = pal_val(i);
            @(negedge clk);
        end
        reg_we = 1'b0;
        reg_write(1'b1, 24'hC0FFEE);   // index wrapped to 0
        model[0] = 24'hC0FFEE;

        pixel(2'd0, 1'b0, 1'b0, 1'b0, 24'hAB0000, got);
        check("R9 wrap to entry 0", got, model[0]);
        pixel(2'd0, 1'b0, 1'b0, 1'b0, 24'h000001, got);
        check("R9/R3 entry 1 kept", got, model[1]);
        pixel(2'd0, 1'b0, 1'b0, 1'b0, 24'h000080, got);
        check("R3 index 128", got, model[128]);
        pixel(2'd0, 1'b0, 1'b0, 1'b0, 24'hFFFFFF, got);
        check("R3 index 255", got, model[255]);
        pixel(2'd2, 1'b0, 1'b0, 1'b0, 24'h102030, got);
        check("R7 per-channel lookup", got,
              {model[8'h10][23:16], model[8'h20][15:8], model[8'h30][7:0]});

        // Index load then explicit write (R9)
        reg_write(1'b0, 24'hFFFF05);
        reg_write(1'b1, 24'h135790);
        model[5] = 24'h135790;
        pixel(2'd0, 1'b0, 1'b0, 1'b0, 24'h000005, got);
        check("R9 index load", got, model[5]);
        reg_write(1'b1, 24'h2468AC);   // goes to 6 after step
        model[6] = 24'h2468AC;
        pixel(2'd0, 1'b0, 1'b0, 1'b0, 24'h000006, got);
        check("R9 step after write", got, model[6]);

        // Same-edge write and lookup (R10)
        reg_write(1'b0, 24'h000040);
        reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = 24'h0BADED;
        in_valid = 1'b1; in_fmt = 2'd0; in_blank = 1'b0; in_pix = 24'h000040;
        @(negedge clk);
        reg_we = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check("R10 old value on collision", out_rgb, model[8'h40]);
        model[8'h40] = 24'h0BADED;
        pixel(2'd0, 1'b0, 1'b0, 1'b0, 24'h000040, got);
        check("R10 new value after", got, model[8'h40]);

        // Streaming latency and blank forcing (R2, R8)
        for (int i = 0; i < 16; i++) begin
            if (i >= 2) begin
                check("R2 out_valid latency", {23'h0, out_valid}, {23'h0, hv[i-2]});
                check("R2 out_blank latency", {23'h0, out_blank}, {23'h0, hb[i-2]});
                check("R6/R8 stream rgb", out_rgb,
                      (hv[i-2] && !hb[i-2]) ? 24'(24'h010203 * (i-2)) : 24'h0);
            end
            hv[i] = (i % 3) != 0;
            hb[i] = (i % 4) == 1;
            in_valid = hv[i]; in_blank = hb[i];
            in_fmt = 2'd2; in_bypass = 1'b1;
            in_pix = 24'(24'h010203 * i);
            @(negedge clk);
        end
        in_valid = 1'b0; in_blank = 1'b0;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule